// File: doc/BRIEF.md
# Maskable Smart Card Interrupt Aggregator

This block merges the interrupt causes of a smart card interface into a single active-high interrupt line. It has three kinds of cause. One is a buffer flag, raised by the UART when its transmit buffer empties or its receive buffer fills. Another is an auxiliary pin that may toggle at any time, with no relation to the clock. The last is a vector of priority status flags. The UART logic that raises the buffer and priority flags sits outside this block, so those flags arrive here as level inputs.

Software reaches the block through a small register port with four addresses:

| Address | Register | Contents |
|---|---|---|
| 0 | Control | Two mask bits |
| 1 | Pin status | The sticky auxiliary-change flag, which clears when this register is read |
| 2 | Buffer status | A live copy of the buffer flag, so the flag can be polled while its interrupt is masked |
| 3 | None | Reads as zero |

The auxiliary flag is set by every pin change, whatever its mask says. The masks only decide whether a pending cause reaches the interrupt line.

Top module: `sc_irq_hub`

## Requirements
- R1: With control bit 6 (buffer mask) at 0, a high `buf_flag_i` drives `irq_o` high on the next clock edge. With bit 6 at 1, the buffer flag has no effect on `irq_o`.
- R2: Reading address 2 returns `buf_flag_i` in bit 0, whatever the masks are set to. All other bits of that register read 0, and reading it changes no state.
- R3: A rising or falling edge on `aux_pin_i` is first passed through two synchroniser flops. The sticky flag (address 1, bit 0) then reads 1 from the third clock edge after the pin change.
- R4: The sticky flag is set whatever the value of control bit 5 (auxiliary mask).
- R5: With control bit 5 at 0, a set sticky flag drives `irq_o` high. With bit 5 at 1, the sticky flag has no effect on `irq_o`.
- R6: Reading address 1 (`reg_rd_i` high) returns the flag, and the flag is clear after that clock edge. If a new pin edge is detected in the same cycle as the read, the flag stays set.
- R7: Any high bit of `pri_flags_i` drives `irq_o` high on the next edge, whatever either mask is set to.
- R8: Control bit 7 is reserved: it reads 0 and writes to it are ignored. Bits 4 to 0 also read 0. Writes to address 0 update bits 6 and 5, and reads of address 0 return them.
- R9: `irq_o` is a register holding the OR of all unmasked pending causes. It goes low one edge after the last cause is cleared or masked.
- R10: After reset, `irq_o` is 0, the sticky flag is 0 and both mask bits are 0.

Register reads are combinational on `reg_rdata_o` for the current `reg_addr_i`. A write to address 0 takes effect at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_addr_i | input | 2 | Register address |
| reg_wr_i | input | 1 | Write strobe |
| reg_rd_i | input | 1 | Read strobe; a read of address 1 clears the sticky flag |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the addressed register |
| buf_flag_i | input | 1 | Transmit-empty / receive-full flag from the UART |
| pri_flags_i | input | NPRI | Priority status flags |
| aux_pin_i | input | 1 | Asynchronous auxiliary interrupt pin |
| irq_o | output | 1 | Active-high merged interrupt |

## Verification
Assertions check four behaviours on every cycle:
- A detected pin edge sets the sticky flag.
- A read without a competing edge clears it.
- A priority flag or an unmasked buffer flag forces the interrupt high.
- The line drops when every cause is masked or idle.

Only the bench scenarios can show the rest:
- The three-edge latency from an asynchronous pin change to the visible flag.
- The tie case where a read coincides with a fresh edge.
- The contents of the control register after writes to its reserved bit.
- The buffer status copy staying readable while its interrupt is masked.

These are checked against a cycle model over random traffic and directed cases.

// File: rtl/sc_irq_pkg.sv
package sc_irq_pkg;
  localparam int unsigned REG_AW = 2;
  localparam int unsigned REG_DW = 8;

  localparam logic [REG_AW-1:0] ADDR_CTRL = 2'd0;
  localparam logic [REG_AW-1:0] ADDR_PIN  = 2'd1;
  localparam logic [REG_AW-1:0] ADDR_BUF  = 2'd2;

  localparam int unsigned BIT_BUF_MASK = 6;
  localparam int unsigned BIT_AUX_MASK = 5;
  localparam int unsigned BIT_FLAG     = 0;
endpackage

// File: rtl/sc_aux_catch.sv
module sc_aux_catch #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic clr_i,
  output logic edge_o,
  output logic flag_o
);
  localparam int unsigned CHAIN = STAGES + 1;

  logic [CHAIN-1:0] chain_q, chain_d;
  logic             flag_q, flag_d;

  always_comb begin
    chain_d[0] = pin_i;
  end

  for (genvar g = 1; g < CHAIN; g++) begin : g_chain
    always_comb chain_d[g] = chain_q[g-1];
  end

  assign edge_o = chain_q[CHAIN-1] ^ chain_q[CHAIN-2];

  always_comb begin
    flag_d = flag_q;
    if (clr_i)  flag_d = 1'b0;
    if (edge_o) flag_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
      flag_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      flag_q  <= flag_d;
    end
  end

  assign flag_o = flag_q;

  assert_edge_sets_flag_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o |=> flag_o);
  assert_read_clears_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !edge_o) |=> !flag_o);
endmodule

// File: rtl/sc_irq_regs.sv
module sc_irq_regs
  import sc_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [REG_DW-1:0] wdata_i,
  input  logic              pin_flag_i,
  input  logic              buf_flag_i,
  output logic [REG_DW-1:0] rdata_o,
  output logic              buf_mask_o,
  output logic              aux_mask_o,
  output logic              pin_clr_o
);
  logic buf_mask_q, buf_mask_d;
  logic aux_mask_q, aux_mask_d;
  logic ctrl_we;

  assign ctrl_we = wr_i && (addr_i == ADDR_CTRL);

  always_comb begin
    buf_mask_d = buf_mask_q;
    aux_mask_d = aux_mask_q;
    if (ctrl_we) begin
      buf_mask_d = wdata_i[BIT_BUF_MASK];
      aux_mask_d = wdata_i[BIT_AUX_MASK];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_mask_q <= 1'b0;
      aux_mask_q <= 1'b0;
    end else begin
      buf_mask_q <= buf_mask_d;
      aux_mask_q <= aux_mask_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_CTRL: begin
        rdata_o[BIT_BUF_MASK] = buf_mask_q;
        rdata_o[BIT_AUX_MASK] = aux_mask_q;
      end
      ADDR_PIN: rdata_o[BIT_FLAG] = pin_flag_i;
      ADDR_BUF: rdata_o[BIT_FLAG] = buf_flag_i;
      default:  rdata_o = '0;
    endcase
  end

  assign pin_clr_o  = rd_i && (addr_i == ADDR_PIN);
  assign buf_mask_o = buf_mask_q;
  assign aux_mask_o = aux_mask_q;

  assert_ctrl_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we |=> (buf_mask_o == $past(wdata_i[BIT_BUF_MASK])) &&
                (aux_mask_o == $past(wdata_i[BIT_AUX_MASK])));
endmodule

// File: rtl/sc_irq_merge.sv
module sc_irq_merge #(
  parameter int unsigned NPRI = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            buf_flag_i,
  input  logic            buf_mask_i,
  input  logic            aux_flag_i,
  input  logic            aux_mask_i,
  input  logic [NPRI-1:0] pri_i,
  output logic            irq_o
);
  logic irq_q, irq_d;
  logic buf_live, aux_live, pri_live;

  always_comb begin
    buf_live = buf_flag_i && !buf_mask_i;
    aux_live = aux_flag_i && !aux_mask_i;
    pri_live = |pri_i;
    irq_d    = buf_live || aux_live || pri_live;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= irq_d;
  end

  assign irq_o = irq_q;

  assert_pri_forces_irq_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|pri_i) |=> irq_o);
  assert_buf_unmasked_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (buf_flag_i && !buf_mask_i) |=> irq_o);
  assert_quiet_when_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(|pri_i) && !(buf_flag_i && !buf_mask_i) && !(aux_flag_i && !aux_mask_i))
      |=> !irq_o);
endmodule

// File: rtl/sc_irq_hub.sv
module sc_irq_hub
  import sc_irq_pkg::*;
#(
  parameter int unsigned NPRI      = 4,
  parameter int unsigned SYNC_LEN  = 2,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [REG_DW-1:0] reg_wdata_i,
  output logic [REG_DW-1:0] reg_rdata_o,
  input  logic              buf_flag_i,
  input  logic [NPRI-1:0]   pri_flags_i,
  input  logic              aux_pin_i,
  output logic              irq_o
);
  logic [RST_STAGES-1:0] rst_sync_q;
  logic                  rst_n_int;
  logic                  pin_edge, pin_flag, pin_clr;
  logic                  buf_mask, aux_mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[RST_STAGES-1];

  sc_aux_catch #(.STAGES(SYNC_LEN)) i_catch (
    .clk_i  (clk_i),
    .rst_ni (rst_n_int),
    .pin_i  (aux_pin_i),
    .clr_i  (pin_clr),
    .edge_o (pin_edge),
    .flag_o (pin_flag)
  );

  sc_irq_regs i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_int),
    .addr_i     (reg_addr_i),
    .wr_i       (reg_wr_i),
    .rd_i       (reg_rd_i),
    .wdata_i    (reg_wdata_i),
    .pin_flag_i (pin_flag),
    .buf_flag_i (buf_flag_i),
    .rdata_o    (reg_rdata_o),
    .buf_mask_o (buf_mask),
    .aux_mask_o (aux_mask),
    .pin_clr_o  (pin_clr)
  );

  sc_irq_merge #(.NPRI(NPRI)) i_merge (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_int),
    .buf_flag_i (buf_flag_i),
    .buf_mask_i (buf_mask),
    .aux_flag_i (pin_flag),
    .aux_mask_i (aux_mask),
    .pri_i      (pri_flags_i),
    .irq_o      (irq_o)
  );

  assert_flag_ignores_mask_R4: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    (pin_edge && aux_mask) |=> pin_flag);
endmodule

// File: tb/test_sc_irq_hub.sv
module test_sc_irq_hub;
  localparam int NPRI = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [1:0]      addr = '0;
  logic            wr = 1'b0, rd = 1'b0;
  logic [7:0]      wdata = '0;
  logic [7:0]      rdata;
  logic            bufl = 1'b0;
  logic [NPRI-1:0] pri = '0;
  logic            aux = 1'b0;
  logic            irq;

  int n_chk = 0, n_bad = 0;
  logic [2:0] m_pipe = '0;
  logic m_flag = 0, m_bmask = 0, m_amask = 0, m_irq = 0;

  always #2.5 clk = ~clk;

  sc_irq_hub #(.NPRI(NPRI)) i_sc_irq_hub (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_wr_i(wr), .reg_rd_i(rd),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .buf_flag_i(bufl),
    .pri_flags_i(pri), .aux_pin_i(aux), .irq_o(irq));

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_rdata(input logic [1:0] a);
    case (a)
      2'd0:    return {1'b0, m_bmask, m_amask, 5'b0};
      2'd1:    return {7'b0, m_flag};
      2'd2:    return {7'b0, bufl};
      default: return 8'h00;
    endcase
  endfunction

  function automatic string rtag(input logic [1:0] a);
    case (a)
      2'd0:    return "R8";
      2'd1:    return "R6";
      2'd2:    return "R2";
      default: return "R8";
    endcase
  endfunction

  // drive for one cycle, check, then update model at the edge
  task automatic step(input logic [1:0] a, input logic w, input logic r,
                      input logic [7:0] wd, input logic b, input logic [NPRI-1:0] p,
                      input logic x);
    logic edge_now;
    check("R9", {7'b0, irq}, {7'b0, m_irq});
    addr = a; wr = w; rd = r; wdata = wd; bufl = b; pri = p; aux = x;
    #1;
    check(rtag(a), rdata, exp_rdata(a));
    @(posedge clk);
    edge_now = m_pipe[2] ^ m_pipe[1];
    m_irq    = (b & ~m_bmask) | (m_flag & ~m_amask) | (|p);
    if (r && a == 2'd1) m_flag = 1'b0;
    if (edge_now) m_flag = 1'b1;
    if (w && a == 2'd0) begin m_bmask = wd[6]; m_amask = wd[5]; end
    m_pipe = {m_pipe[1:0], x};
    @(negedge clk);
  endtask

  task automatic peek(input string tag, input logic [1:0] a, input logic [7:0] exp);
    addr = a; rd = 1'b0; wr = 1'b0;
    #1;
    check(tag, rdata, exp);
  endtask

  initial begin : watchdog
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int seed;
    seed = 42;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R10", {7'b0, irq}, 8'h00);
    peek("R10", 2'd1, 8'h00);
    peek("R10", 2'd0, 8'h00);

    // R8: reserved and unused bits ignore writes
    step(2'd0, 1, 0, 8'hFF, 0, '0, 0);
    peek("R8", 2'd0, 8'h60);
    step(2'd0, 1, 0, 8'h00, 0, '0, 0);

    // R1: buffer flag unmasked then masked
    step(2'd2, 0, 0, 8'h00, 1, '0, 0);
    check("R1", {7'b0, irq}, 8'h01);
    step(2'd0, 1, 0, 8'h40, 1, '0, 0);
    step(2'd2, 0, 0, 8'h00, 1, '0, 0);
    check("R1", {7'b0, irq}, 8'h00);
    peek("R2", 2'd2, 8'h01);

    // R3/R4/R5: rising edge with aux masked
    step(2'd0, 1, 0, 8'h60, 0, '0, 1);
    step(2'd3, 0, 0, 8'h00, 0, '0, 1);
    peek("R3", 2'd1, 8'h00);
    step(2'd3, 0, 0, 8'h00, 0, '0, 1);
    peek("R4", 2'd1, 8'h01);
    step(2'd3, 0, 0, 8'h00, 0, '0, 1);
    check("R5", {7'b0, irq}, 8'h00);
    step(2'd0, 1, 0, 8'h00, 0, '0, 1);
    step(2'd3, 0, 0, 8'h00, 0, '0, 1);
    check("R5", {7'b0, irq}, 8'h01);

    // R6: clearing read
    step(2'd1, 0, 1, 8'h00, 0, '0, 1);
    peek("R6", 2'd1, 8'h00);
    step(2'd3, 0, 0, 8'h00, 0, '0, 1);
    check("R9", {7'b0, irq}, 8'h00);

    // R6: falling edge detected in the cycle of the read keeps the flag
    step(2'd3, 0, 0, 8'h00, 0, '0, 0);
    step(2'd3, 0, 0, 8'h00, 0, '0, 0);
    step(2'd1, 0, 1, 8'h00, 0, '0, 0);
    peek("R6", 2'd1, 8'h01);
    check("R3", {7'b0, m_flag}, 8'h01);
    step(2'd1, 0, 1, 8'h00, 0, '0, 0);

    // R7: priority flag with everything masked
    step(2'd0, 1, 0, 8'h60, 1, '0, 0);
    step(2'd3, 0, 0, 8'h00, 1, 4'b0100, 0);
    check("R7", {7'b0, irq}, 8'h01);
    step(2'd3, 0, 0, 8'h00, 1, '0, 0);
    check("R9", {7'b0, irq}, 8'h00);

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [1:0] a;
      logic w, r;
      a = 2'($urandom_range(0, 3));
      w = ($urandom_range(0, 7) == 0);
      r = ($urandom_range(0, 5) == 0);
      step(a, w, r, 8'($urandom), 1'($urandom),
           ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'b0,
           ($urandom_range(0, 9) == 0) ? ~aux : aux);
    end
    step(2'd3, 0, 0, 8'h00, 0, '0, aux);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule